// File: doc/BRIEF.md
# Fast System-Return State Update Unit

This unit computes the architectural state that a processor core installs when system code at the highest privilege level hands control back to user code through the fast return path. It holds one writable model-specific register, the selector base. Software reaches it through a small MSR read/write port. The register supplies the user code and stack selectors. No descriptor table is consulted.

When the execute strobe is raised, the unit samples several inputs:
- the current privilege level,
- the real-address, virtual-8086 and long-mode flags,
- the 64-bit operand-size flag,
- the two general registers that carry the user instruction pointer (RDX) and the user stack pointer (RCX).

It then does exactly one of two things. It raises a general-protection fault and keeps every output state register unchanged. Or it installs a new architectural state: the new pointers, the selectors, fixed descriptor-cache attributes, the new execution mode and privilege level 3. The surrounding pipeline reads the result one clock after the strobe.

Top module: `fsr_unit`

## Requirements
- R1: The selector-base MSR is 32 bits wide and lives at address 0x174. A write there is visible on `msrRdData` from the next cycle. A read at any other address returns 0. A write to any other address leaves the register unchanged.
- R2: An execute strobe with `curCpl` different from 0 produces a fault.
- R3: An execute strobe with `realMode` or `v86Mode` set produces a fault.
- R4: An execute strobe while MSR bits 15:2 are all zero produces a fault.
- R5: The target mode is chosen as follows: 64-bit when both `longMode` and `opSize64` are set, compatibility when only `longMode` is set, and protected otherwise. `execMode` encodes these as 2 = 64-bit, 1 = compatibility, 0 = protected.
- R6: On success, `newRip` takes `rdxIn` and `newRsp` takes `rcxIn`. For a target other than 64-bit, only bits 31:0 are kept and bits 63:32 are zero.
- R7: For a 64-bit target, a non-canonical `rdxIn` or `rcxIn` produces a fault. A value is canonical when bits 63:47 are all equal.
- R8: On success, `csSel` is ((MSR[15:0] + 32) | 3) for a 64-bit target and ((MSR[15:0] + 16) | 3) otherwise. `ssSel` is (`csSel` + 8), with the RPL bits also at 3. All arithmetic is modulo 2^16.
- R9: On success, `csAttr` is 0xAFB for a 64-bit target and 0xCFB otherwise, and `ssAttr` is 0xCF3. The attribute word is laid out as G, D, L, AVL, P, DPL[1:0], S, Type[3:0], from bit 11 down to bit 0.
- R10: After reset, every state output and `cpl` is 0. After a successful return, `cpl` is 3.
- R11: Every execute strobe yields exactly one single-cycle pulse, either `doneStb` or `faultStb`, in the cycle after the strobe. A fault leaves all state outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| msrAddr | input | 32 | MSR access address |
| msrWrEn | input | 1 | MSR write enable |
| msrWrData | input | 32 | MSR write data |
| msrRdData | output | 32 | MSR read data (combinational) |
| execStb | input | 1 | Execute the return |
| curCpl | input | 2 | Current privilege level |
| realMode | input | 1 | Real-address mode active |
| v86Mode | input | 1 | Virtual-8086 mode active |
| longMode | input | 1 | Long mode active |
| opSize64 | input | 1 | 64-bit operand size |
| rdxIn | input | 64 | Source of new instruction pointer |
| rcxIn | input | 64 | Source of new stack pointer |
| doneStb | output | 1 | Successful return pulse |
| faultStb | output | 1 | General-protection fault pulse |
| newRip | output | 64 | Instruction pointer state |
| newRsp | output | 64 | Stack pointer state |
| csSel | output | 16 | Code selector state |
| ssSel | output | 16 | Stack selector state |
| csAttr | output | 12 | Code descriptor-cache attributes |
| ssAttr | output | 12 | Stack descriptor-cache attributes |
| cpl | output | 2 | Privilege level state |
| execMode | output | 2 | Execution mode state |

## Verification
Each result has a fixed latency:

- **MSR write.** It takes one clock edge. The bench reads the register back at the falling edge after the write's rising edge, with a small settling delay for the combinational read path.
- **Execute.** All results are registered once. The strobe is driven at a falling edge. The pulses, pointers, selectors, attributes, mode and privilege level are compared at the next falling edge, exactly one rising edge later.
- **Pulse width.** A further idle falling edge is sampled now and then to confirm that both pulses have dropped.
- **Faults.** After a fault, the state outputs are compared against the bench's model of the previous state. This shows that nothing was written.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned MSR_W  = 32;
  localparam int unsigned REG_W  = 64;
  localparam int unsigned SEL_W  = 16;
  localparam int unsigned ATTR_W = 12;

  typedef enum logic [1:0] {
    MODE_PROT   = 2'd0,
    MODE_COMPAT = 2'd1,
    MODE_64     = 2'd2
  } exec_mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       load;
    exec_mode_e tgtMode;
  } dp_ctrl_t;

  // attribute word: G D L AVL P DPL[1:0] S Type[3:0]
  localparam logic [ATTR_W-1:0] ATTR_CODE32 = 12'hCFB;
  localparam logic [ATTR_W-1:0] ATTR_CODE64 = 12'hAFB;
  localparam logic [ATTR_W-1:0] ATTR_STACK  = 12'hCF3;

  localparam logic [SEL_W-1:0] SEL_OFF_32 = 16'd16;
  localparam logic [SEL_W-1:0] SEL_OFF_64 = 16'd32;
  localparam logic [SEL_W-1:0] SEL_SS_GAP = 16'd8;
endpackage

// File: rtl/fsr_ctrl.sv
module fsr_ctrl
  import fsr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       execStb,
  input  logic [1:0] curCpl,
  input  logic       realMode,
  input  logic       v86Mode,
  input  logic       longMode,
  input  logic       opSize64,
  input  logic       selZero,
  input  logic       rdxCanon,
  input  logic       rcxCanon,
  output dp_ctrl_t   dpCtrl,
  output logic       doneStb,
  output logic       faultStb
);
  exec_mode_e tgtMode;
  logic       badPriv;
  logic       badMode;
  logic       badPtr;
  logic       reject;

  always_comb begin
    if (longMode && opSize64) tgtMode = MODE_64;
    else if (longMode)        tgtMode = MODE_COMPAT;
    else                      tgtMode = MODE_PROT;
  end

  assign badPriv = (curCpl != 2'd0);
  assign badMode = realMode | v86Mode;
  assign badPtr  = (tgtMode == MODE_64) && !(rdxCanon && rcxCanon);
  assign reject  = badPriv | badMode | selZero | badPtr;

  assign dpCtrl.load    = execStb && !reject;
  assign dpCtrl.tgtMode = tgtMode;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneStb  <= 1'b0;
      faultStb <= 1'b0;
    end else begin
      doneStb  <= execStb && !reject;
      faultStb <= execStb && reject;
    end
  end

  // R11
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(doneStb && faultStb));

  // R11
  pulse_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneStb || faultStb) |-> $past(execStb));

  // R2
  priv_fault_chk: assert property (@(posedge clk) disable iff (!rstN)
    (execStb && curCpl != 2'd0) |=> faultStb);

  // R3
  mode_fault_chk: assert property (@(posedge clk) disable iff (!rstN)
    (execStb && (realMode || v86Mode)) |=> faultStb);
endmodule

// File: rtl/fsr_datapath.sv
module fsr_datapath
  import fsr_pkg::*;
#(
  parameter int unsigned       VA_BITS  = 48,
  parameter logic [ADDR_W-1:0] MSR_ADDR = 32'h0000_0174
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] msrAddr,
  input  logic              msrWrEn,
  input  logic [MSR_W-1:0]  msrWrData,
  output logic [MSR_W-1:0]  msrRdData,
  input  logic [REG_W-1:0]  rdxIn,
  input  logic [REG_W-1:0]  rcxIn,
  input  dp_ctrl_t          dpCtrl,
  output logic              selZero,
  output logic              rdxCanon,
  output logic              rcxCanon,
  output logic [REG_W-1:0]  newRip,
  output logic [REG_W-1:0]  newRsp,
  output logic [SEL_W-1:0]  csSel,
  output logic [SEL_W-1:0]  ssSel,
  output logic [ATTR_W-1:0] csAttr,
  output logic [ATTR_W-1:0] ssAttr,
  output logic [1:0]        cpl,
  output exec_mode_e        execMode
);
  localparam int unsigned HI_W = REG_W - VA_BITS + 1;

  logic [MSR_W-1:0] selBaseMsr;
  logic             msrHit;

  assign msrHit = (msrAddr == MSR_ADDR);

  always_ff @(posedge clk) begin
    if (!rstN)                 selBaseMsr <= '0;
    else if (msrWrEn && msrHit) selBaseMsr <= msrWrData;
  end

  assign msrRdData = msrHit ? selBaseMsr : '0;
  assign selZero   = (selBaseMsr[15:2] == 14'd0);

  // canonical-address checks, one per source register
  logic [REG_W-1:0] ptrSrc [2];
  logic [1:0]       ptrCanon;
  assign ptrSrc[0] = rdxIn;
  assign ptrSrc[1] = rcxIn;

  for (genvar g = 0; g < 2; g++) begin : g_canon
    logic [HI_W-1:0] upper;
    assign upper       = ptrSrc[g][REG_W-1:VA_BITS-1];
    assign ptrCanon[g] = (&upper) | ~(|upper);
  end

  assign rdxCanon = ptrCanon[0];
  assign rcxCanon = ptrCanon[1];

  // next-state computation
  logic             to64;
  logic [SEL_W-1:0] selBase;
  logic [SEL_W-1:0] csNext;
  logic [SEL_W-1:0] ssNext;
  logic [REG_W-1:0] ripNext;
  logic [REG_W-1:0] rspNext;

  assign to64    = (dpCtrl.tgtMode == MODE_64);
  assign selBase = selBaseMsr[SEL_W-1:0] + (to64 ? SEL_OFF_64 : SEL_OFF_32);
  assign csNext  = selBase | 16'h0003;
  assign ssNext  = (selBase + SEL_SS_GAP) | 16'h0003;
  assign ripNext = to64 ? rdxIn : {32'd0, rdxIn[31:0]};
  assign rspNext = to64 ? rcxIn : {32'd0, rcxIn[31:0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      newRip   <= '0;
      newRsp   <= '0;
      csSel    <= '0;
      ssSel    <= '0;
      csAttr   <= '0;
      ssAttr   <= '0;
      cpl      <= 2'd0;
      execMode <= MODE_PROT;
    end else if (dpCtrl.load) begin
      newRip   <= ripNext;
      newRsp   <= rspNext;
      csSel    <= csNext;
      ssSel    <= ssNext;
      csAttr   <= to64 ? ATTR_CODE64 : ATTR_CODE32;
      ssAttr   <= ATTR_STACK;
      cpl      <= 2'd3;
      execMode <= dpCtrl.tgtMode;
    end
  end

  // R6
  truncation_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(dpCtrl.load) && execMode != MODE_64) |->
      (newRip[63:32] == 32'd0 && newRsp[63:32] == 32'd0));

  // R8
  selector_rpl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(dpCtrl.load) |-> (csSel[1:0] == 2'b11 && ssSel == csSel + SEL_SS_GAP));

  // R10
  user_cpl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(dpCtrl.load) |-> cpl == 2'd3);
endmodule

// File: rtl/fsr_unit.sv
module fsr_unit
  import fsr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] msrAddr,
  input  logic        msrWrEn,
  input  logic [31:0] msrWrData,
  output logic [31:0] msrRdData,
  input  logic        execStb,
  input  logic [1:0]  curCpl,
  input  logic        realMode,
  input  logic        v86Mode,
  input  logic        longMode,
  input  logic        opSize64,
  input  logic [63:0] rdxIn,
  input  logic [63:0] rcxIn,
  output logic        doneStb,
  output logic        faultStb,
  output logic [63:0] newRip,
  output logic [63:0] newRsp,
  output logic [15:0] csSel,
  output logic [15:0] ssSel,
  output logic [11:0] csAttr,
  output logic [11:0] ssAttr,
  output logic [1:0]  cpl,
  output logic [1:0]  execMode
);
  dp_ctrl_t   dpCtrl;
  logic       selZero;
  logic       rdxCanon;
  logic       rcxCanon;
  exec_mode_e modeState;

  fsr_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .execStb  (execStb),
    .curCpl   (curCpl),
    .realMode (realMode),
    .v86Mode  (v86Mode),
    .longMode (longMode),
    .opSize64 (opSize64),
    .selZero  (selZero),
    .rdxCanon (rdxCanon),
    .rcxCanon (rcxCanon),
    .dpCtrl   (dpCtrl),
    .doneStb  (doneStb),
    .faultStb (faultStb)
  );

  fsr_datapath i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .msrAddr   (msrAddr),
    .msrWrEn   (msrWrEn),
    .msrWrData (msrWrData),
    .msrRdData (msrRdData),
    .rdxIn     (rdxIn),
    .rcxIn     (rcxIn),
    .dpCtrl    (dpCtrl),
    .selZero   (selZero),
    .rdxCanon  (rdxCanon),
    .rcxCanon  (rcxCanon),
    .newRip    (newRip),
    .newRsp    (newRsp),
    .csSel     (csSel),
    .ssSel     (ssSel),
    .csAttr    (csAttr),
    .ssAttr    (ssAttr),
    .cpl       (cpl),
    .execMode  (modeState)
  );

  assign execMode = modeState;

  // R11
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    faultStb |-> ($stable(newRip) && $stable(newRsp) && $stable(csSel) &&
                  $stable(ssSel) && $stable(cpl) && $stable(execMode)));
endmodule

// File: tb/test_fsr_unit.sv
module test_fsr_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] msrAddr = 32'h174;
  logic        msrWrEn = 1'b0;
  logic [31:0] msrWrData = '0;
  logic [31:0] msrRdData;
  logic        execStb = 1'b0;
  logic [1:0]  curCpl = 2'd0;
  logic        realMode = 1'b0, v86Mode = 1'b0, longMode = 1'b0, opSize64 = 1'b0;
  logic [63:0] rdxIn = '0, rcxIn = '0;
  logic        doneStb, faultStb;
  logic [63:0] newRip, newRsp;
  logic [15:0] csSel, ssSel;
  logic [11:0] csAttr, ssAttr;
  logic [1:0]  cpl, execMode;

  int unsigned nChecks = 0;
  int unsigned nFails  = 0;

  // bench model of architectural state
  logic [31:0] mMsr = '0;
  logic [63:0] eRip = '0, eRsp = '0;
  logic [15:0] eCs = '0, eSs = '0;
  logic [11:0] eCsA = '0, eSsA = '0;
  logic [1:0]  eCpl = '0, eMode = '0;

  fsr_unit i_fsr_unit (
    .clk(clk), .rstN(rstN), .msrAddr(msrAddr), .msrWrEn(msrWrEn),
    .msrWrData(msrWrData), .msrRdData(msrRdData), .execStb(execStb),
    .curCpl(curCpl), .realMode(realMode), .v86Mode(v86Mode),
    .longMode(longMode), .opSize64(opSize64), .rdxIn(rdxIn), .rcxIn(rcxIn),
    .doneStb(doneStb), .faultStb(faultStb), .newRip(newRip), .newRsp(newRsp),
    .csSel(csSel), .ssSel(ssSel), .csAttr(csAttr), .ssAttr(ssAttr),
    .cpl(cpl), .execMode(execMode)
  );

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit isCanon(input logic [63:0] v);
    return (&v[63:47]) || !(|v[63:47]);
  endfunction

  function automatic logic [63:0] mkPtr(input bit canon);
    logic [63:0] v;
    v = {$urandom, $urandom};
    if (canon) v[63:47] = {17{v[47]}};
    return v;
  endfunction

  task automatic msrWrite(input logic [31:0] a, input logic [31:0] d);
    msrAddr = a; msrWrData = d; msrWrEn = 1'b1;
    @(negedge clk);
    msrWrEn = 1'b0;
    if (a == 32'h174) mMsr = d;
  endtask

  task automatic msrRead(input logic [31:0] a, input logic [31:0] exp);
    msrAddr = a;
    #1;
    check(msrRdData === exp, "R1", {32'd0, msrRdData}, {32'd0, exp});
    msrAddr = 32'h174;
  endtask

  task automatic runExec(input logic [1:0] c, input bit rm, input bit vm,
                         input bit lm, input bit o64, input logic [63:0] rdx,
                         input logic [63:0] rcx);
    logic [1:0]  tMode;
    bit          flt;
    string       fTag;
    logic [15:0] b;
    tMode = (lm && o64) ? 2'd2 : (lm ? 2'd1 : 2'd0);
    flt = 1'b0; fTag = "R11";
    if (tMode == 2'd2 && !(isCanon(rdx) && isCanon(rcx))) begin flt = 1; fTag = "R7"; end
    if (mMsr[15:2] == 14'd0) begin flt = 1; fTag = "R4"; end
    if (rm || vm) begin flt = 1; fTag = "R3"; end
    if (c != 2'd0) begin flt = 1; fTag = "R2"; end
    if (!flt) begin
      b     = mMsr[15:0] + ((tMode == 2'd2) ? 16'd32 : 16'd16);
      eCs   = b | 16'd3;
      eSs   = (b + 16'd8) | 16'd3;
      eRip  = (tMode == 2'd2) ? rdx : {32'd0, rdx[31:0]};
      eRsp  = (tMode == 2'd2) ? rcx : {32'd0, rcx[31:0]};
      eCsA  = (tMode == 2'd2) ? 12'hAFB : 12'hCFB;
      eSsA  = 12'hCF3;
      eCpl  = 2'd3;
      eMode = tMode;
    end
    curCpl = c; realMode = rm; v86Mode = vm; longMode = lm; opSize64 = o64;
    rdxIn = rdx; rcxIn = rcx; execStb = 1'b1;
    @(negedge clk);
    execStb = 1'b0;
    check(faultStb === flt, fTag, {63'd0, faultStb}, {63'd0, flt});
    check(doneStb === !flt, "R11", {63'd0, doneStb}, {63'd0, !flt});
    check(newRip === eRip, flt ? "R11" : "R6", newRip, eRip);
    check(newRsp === eRsp, flt ? "R11" : "R6", newRsp, eRsp);
    check(csSel === eCs && ssSel === eSs, flt ? "R11" : "R8",
          {csSel, ssSel}, {eCs, eSs});
    check(csAttr === eCsA && ssAttr === eSsA, "R9", {csAttr, ssAttr}, {eCsA, eSsA});
    check(execMode === eMode, "R5", {62'd0, execMode}, {62'd0, eMode});
    check(cpl === eCpl, "R10", {62'd0, cpl}, {62'd0, eCpl});
  endtask

  task automatic idleCheck();
    @(negedge clk);
    check(!doneStb && !faultStb, "R11", {62'd0, doneStb, faultStb}, 64'd0);
  endtask

  initial begin
    #(4 * 200000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(newRip === 0 && newRsp === 0 && csSel === 0 && ssSel === 0 &&
          cpl === 0 && execMode === 0 && csAttr === 0 && !doneStb && !faultStb,
          "R10", {csSel, ssSel, 28'd0, cpl, execMode}, 64'd0);
    msrRead(32'h174, 32'h0);

    // R1 MSR access
    msrWrite(32'h174, 32'hA5A5_0010);
    msrRead(32'h174, 32'hA5A5_0010);
    msrRead(32'h175, 32'h0);
    msrWrite(32'h176, 32'hFFFF_FFFF);
    msrRead(32'h174, 32'hA5A5_0010);

    // R4 zero selector field (low bits set only)
    msrWrite(32'h174, 32'h0000_0003);
    runExec(2'd0, 0, 0, 0, 0, 64'h1234, 64'h5678);
    idleCheck();

    msrWrite(32'h174, 32'h0000_0010);
    // R5 protected, R6 truncation
    runExec(2'd0, 0, 0, 0, 0, 64'hDEAD_BEEF_1234_5678, 64'hCAFE_0000_8765_4321);
    // R5 compat
    runExec(2'd0, 0, 0, 1, 0, 64'hFFFF_FFFF_0000_1000, 64'h1_0000_2000);
    // R5 64-bit, canonical boundaries R7
    runExec(2'd0, 0, 0, 1, 1, 64'h0000_7FFF_FFFF_FFFF, 64'hFFFF_8000_0000_0000);
    runExec(2'd0, 0, 0, 1, 1, 64'h0000_8000_0000_0000, 64'h10);
    runExec(2'd0, 0, 0, 1, 1, 64'h10, 64'hFFFF_7FFF_FFFF_FFFF);
    // non-canonical ignored when target is not 64-bit
    runExec(2'd0, 0, 0, 1, 0, 64'h0000_8000_0000_0040, 64'h20);
    // R2 privilege
    runExec(2'd1, 0, 0, 1, 1, 64'h100, 64'h200);
    runExec(2'd3, 0, 0, 0, 0, 64'h100, 64'h200);
    // R3 real / v86
    runExec(2'd0, 1, 0, 0, 0, 64'h100, 64'h200);
    runExec(2'd0, 0, 1, 0, 0, 64'h100, 64'h200);
    idleCheck();
    // R8 wraparound
    msrWrite(32'h174, 32'h0000_FFF0);
    runExec(2'd0, 0, 0, 1, 1, 64'h40, 64'h80);
    runExec(2'd0, 0, 0, 0, 0, 64'h40, 64'h80);

    for (int i = 0; i < 600; i++) begin
      if ((i % 50) == 0) begin
        logic [31:0] m;
        m = $urandom;
        if (($urandom % 8) == 0) m[15:2] = '0;
        msrWrite(32'h174, m);
        msrRead(32'h174, m);
      end
      runExec((($urandom % 4) == 0) ? 2'($urandom) : 2'd0,
              (($urandom % 10) == 0), (($urandom % 10) == 0),
              1'($urandom), 1'($urandom),
              mkPtr(($urandom % 6) != 0), mkPtr(($urandom % 6) != 0));
      if (($urandom % 5) == 0) idleCheck();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule